// File: doc/BRIEF.md
# I2C Pin Override for Software-Driven Bus Recovery

This block sits between an I2C controller engine and the open-drain SDA and SCL pads. In normal operation the pads follow the engine's pull-down requests unchanged. When software sets the override bit, both pads become general-purpose open-drain I/O under register control. A typical use is bus recovery: software pulses SCL by hand until a stuck target releases SDA.

Software reaches the block through a simple register port: one write strobe, an address and write data, plus combinational read data. It can pick the direction of each pin and read the synchronised pad levels. Output levels change in three ways: write-1-to-set, write-1-to-clear, or a direct load of the output latch. A pad that drives a high level, and any pad set as an input, is released and never driven high. Pad levels pass through a two-flop synchroniser before software can read them.

Top module: `i2c_pin_override`

## Requirements
- R1: After reset, the function register reads 0, the direction register reads 0 and the output latch reads 2'b11. The pads follow the engine's pull-down requests.
- R2: While function bit 0 is 0, `scl_pad_low` equals `eng_scl_low` and `sda_pad_low` equals `eng_sda_low`, whatever the direction and latch contents.
- R3: While function bit 0 is 1 and a pin's direction bit is 1 (bit 0 = SCL, bit 1 = SDA), the pad is pulled low exactly when its latch bit is 0. The engine request has no effect.
- R4: While function bit 0 is 1 and a pin's direction bit is 0, that pad is released, whatever its latch bit and the engine request.
- R5: A write to the set register (offset 0x58) sets each latch bit whose write bit (bit 0 = SCL, bit 1 = SDA) is 1. Latch bits whose write bit is 0 keep their value.
- R6: A write to the clear register (offset 0x5C) clears each latch bit whose write bit is 1. Latch bits whose write bit is 0 keep their value.
- R7: A write to the output data register (offset 0x54) loads both latch bits from write bits [1:0]. Reading 0x54 returns the latch in bits [1:0].
- R8: The input register (offset 0x50) returns the SCL level in bit 0 and the SDA level in bit 1. A pad change appears after the second rising clock edge and not after the first.
- R9: The function register (offset 0x48, bit 0) and the direction register (offset 0x4C, bits [1:0]) read back what was written. All bits above the defined fields read 0.
- R10: A write to an unmapped offset changes no register. A read of an unmapped offset, or of the set or clear register, returns 0.
- R11: Writing 0 to function bit 0 hands the pads back to the engine at once, while direction and latch keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| eng_scl_low | input | 1 | Engine request to pull SCL low |
| eng_sda_low | input | 1 | Engine request to pull SDA low |
| scl_pad_in | input | 1 | SCL pad level |
| sda_pad_in | input | 1 | SDA pad level |
| scl_pad_low | output | 1 | Pull SCL pad low |
| sda_pad_low | output | 1 | Pull SDA pad low |

## Verification
The bench builds the block with its defaults: an 8-bit offset, a 16-bit data word and two synchroniser stages. The 16-bit word lets the bench check that the upper read bits stay zero. The two stages let it pin the input latency to an exact edge count. The 8-bit offset leaves room for unmapped offsets next to the register window, so the bench can show that stray writes change nothing.

// File: rtl/i2c_pin_override.sv
module i2c_pin_override #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFS_FUNC = 'h48,
  parameter logic [ADDR_W-1:0] OFS_DIR  = 'h4C,
  parameter logic [ADDR_W-1:0] OFS_LVL  = 'h50,
  parameter logic [ADDR_W-1:0] OFS_DATA = 'h54,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h58,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h5C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              eng_scl_low,
  input  logic              eng_sda_low,
  input  logic              scl_pad_in,
  input  logic              sda_pad_in,
  output logic              scl_pad_low,
  output logic              sda_pad_low
);
  localparam int PAD_W = DATA_W - 2;

  logic       func_en;
  logic [1:0] dir_q;
  logic [1:0] out_q;
  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic [1:0] lvl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      func_en <= 1'b0;
      dir_q   <= 2'b00;
      out_q   <= 2'b11;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_FUNC: func_en <= reg_wdata[0];
        OFS_DIR:  dir_q   <= reg_wdata[1:0];
        OFS_DATA: out_q   <= reg_wdata[1:0];
        OFS_SET:  out_q   <= out_q | reg_wdata[1:0];
        OFS_CLR:  out_q   <= out_q & ~reg_wdata[1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sync <= '1;
      sda_sync <= '1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_pad_in};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_pad_in};
    end
  end

  assign lvl = {sda_sync[SYNC_STAGES-1], scl_sync[SYNC_STAGES-1]};

  always_comb begin
    case (reg_addr)
      OFS_FUNC: reg_rdata = {{(DATA_W-1){1'b0}}, func_en};
      OFS_DIR:  reg_rdata = {{PAD_W{1'b0}}, dir_q};
      OFS_LVL:  reg_rdata = {{PAD_W{1'b0}}, lvl};
      OFS_DATA: reg_rdata = {{PAD_W{1'b0}}, out_q};
      default:  reg_rdata = '0;
    endcase
  end

  assign scl_pad_low = func_en ? (dir_q[0] & ~out_q[0]) : eng_scl_low;
  assign sda_pad_low = func_en ? (dir_q[1] & ~out_q[1]) : eng_sda_low;
endmodule

module i2c_pin_override_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFS_DATA = 'h54,
  parameter logic [ADDR_W-1:0] OFS_SET  = 'h58,
  parameter logic [ADDR_W-1:0] OFS_CLR  = 'h5C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              func_en,
  input logic [1:0]        dir_q,
  input logic [1:0]        out_q,
  input logic [1:0]        lvl,
  input logic              scl_pad_in,
  input logic              eng_scl_low,
  input logic              eng_sda_low,
  input logic              scl_pad_low,
  input logic              sda_pad_low
);
  logic [1:0] since;
  always_ff @(posedge clk) begin
    if (!rst_n) since <= 2'd0;
    else if (since != 2'd3) since <= since + 2'd1;
  end

  a_r2_follow_engine: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |-> (scl_pad_low == eng_scl_low) && (sda_pad_low == eng_sda_low));

  a_r4_input_released: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en && !dir_q[0]) |-> !scl_pad_low);

  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_SET) |=> out_q == ($past(out_q) | $past(reg_wdata[1:0])));

  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CLR) |=> out_q == ($past(out_q) & ~$past(reg_wdata[1:0])));

  a_r7_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_DATA) |=> out_q == $past(reg_wdata[1:0]));

  generate
    if (SYNC_STAGES == 2) begin : g_lat
      a_r8_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 2'd2) |-> lvl[0] == $past(scl_pad_in, 2));
    end
  endgenerate
endmodule

bind i2c_pin_override i2c_pin_override_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES),
  .OFS_DATA(OFS_DATA), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .func_en(func_en), .dir_q(dir_q), .out_q(out_q),
  .lvl(lvl), .scl_pad_in(scl_pad_in), .eng_scl_low(eng_scl_low),
  .eng_sda_low(eng_sda_low), .scl_pad_low(scl_pad_low), .sda_pad_low(sda_pad_low)
);

// File: tb/i2c_pin_override_bench.sv
module i2c_pin_override_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic eng_scl_low = 1'b0, eng_sda_low = 1'b0;
  logic scl_pad_in = 1'b1, sda_pad_in = 1'b1;
  logic scl_pad_low, sda_pad_low;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  i2c_pin_override u_i2c_pin_override (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_scl_low(eng_scl_low), .eng_sda_low(eng_sda_low),
    .scl_pad_in(scl_pad_in), .sda_pad_in(sda_pad_in),
    .scl_pad_low(scl_pad_low), .sda_pad_low(sda_pad_low)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] pads();
    return {14'b0, sda_pad_low, scl_pad_low};
  endfunction

  task automatic t_reset;
    logic [15:0] d;
    rd(8'h48, d); check("R1 func", d, 16'h0);
    rd(8'h4C, d); check("R1 dir", d, 16'h0);
    rd(8'h54, d); check("R1 latch", d, 16'h3);
    eng_scl_low = 1'b1; #1 check("R1 pads", pads(), 16'h1);
    eng_scl_low = 1'b0;
  endtask

  task automatic t_engine_follow;
    wr(8'h4C, 16'h3); wr(8'h54, 16'h0);
    eng_sda_low = 1'b1; #1 check("R2 sda", pads(), 16'h2);
    eng_sda_low = 1'b0; eng_scl_low = 1'b1; #1 check("R2 scl", pads(), 16'h1);
    eng_scl_low = 1'b0; #1 check("R2 none", pads(), 16'h0);
  endtask

  task automatic t_gpio_drive;
    logic [15:0] d;
    wr(8'h48, 16'hFFFF);
    rd(8'h48, d); check("R9 func", d, 16'h1);
    rd(8'h4C, d); check("R9 dir", d, 16'h3);
    eng_scl_low = 1'b1; eng_sda_low = 1'b1;
    wr(8'h54, 16'h1); #1 check("R3 sda low scl hi", pads(), 16'h2);
    rd(8'h54, d); check("R7 readback", d, 16'h1);
    wr(8'h54, 16'hFFFE); #1 check("R3 scl low", pads(), 16'h1);
    rd(8'h54, d); check("R7 load upper ignored", d, 16'h2);
    wr(8'h4C, 16'h2); #1 check("R4 scl input released", pads(), 16'h0);
    wr(8'h54, 16'h0); #1 check("R4 sda only", pads(), 16'h2);
    wr(8'h4C, 16'h0); #1 check("R4 both released", pads(), 16'h0);
    eng_scl_low = 1'b0; eng_sda_low = 1'b0;
  endtask

  task automatic t_set_clear;
    logic [15:0] d;
    wr(8'h54, 16'h0);
    wr(8'h58, 16'h1); rd(8'h54, d); check("R5 set scl", d, 16'h1);
    wr(8'h58, 16'h0); rd(8'h54, d); check("R5 zero no effect", d, 16'h1);
    wr(8'h58, 16'h2); rd(8'h54, d); check("R5 set sda keep scl", d, 16'h3);
    wr(8'h5C, 16'h2); rd(8'h54, d); check("R6 clear sda", d, 16'h1);
    wr(8'h5C, 16'h0); rd(8'h54, d); check("R6 zero no effect", d, 16'h1);
    wr(8'h5C, 16'h3); rd(8'h54, d); check("R6 clear both", d, 16'h0);
    rd(8'h58, d); check("R10 set reads 0", d, 16'h0);
    rd(8'h5C, d); check("R10 clr reads 0", d, 16'h0);
  endtask

  task automatic t_unmapped;
    logic [15:0] d;
    wr(8'h44, 16'hFFFF); wr(8'h60, 16'hFFFF); wr(8'h49, 16'h0);
    rd(8'h48, d); check("R10 func kept", d, 16'h1);
    rd(8'h4C, d); check("R10 dir kept", d, 16'h0);
    rd(8'h54, d); check("R10 latch kept", d, 16'h0);
    rd(8'h60, d); check("R10 unmapped read", d, 16'h0);
  endtask

  task automatic t_sync;
    logic [15:0] d;
    @(negedge clk); sda_pad_in = 1'b0;
    rd(8'h50, d); check("R8 before edge", d, 16'h3);
    @(negedge clk); rd(8'h50, d); check("R8 one edge", d, 16'h3);
    @(negedge clk); rd(8'h50, d); check("R8 two edges", d, 16'h1);
    scl_pad_in = 1'b0;
    @(negedge clk); rd(8'h50, d); check("R8 scl one edge", d, 16'h1);
    @(negedge clk); rd(8'h50, d); check("R8 scl two edges", d, 16'h0);
    sda_pad_in = 1'b1; scl_pad_in = 1'b1;
    repeat (2) @(negedge clk);
    rd(8'h50, d); check("R8 released", d, 16'h3);
  endtask

  task automatic t_handback;
    logic [15:0] d;
    wr(8'h4C, 16'h3); wr(8'h54, 16'h0);
    #1 check("R11 gpio drives", pads(), 16'h3);
    eng_sda_low = 1'b1;
    wr(8'h48, 16'h0); #1 check("R11 engine back", pads(), 16'h2);
    rd(8'h4C, d); check("R11 dir kept", d, 16'h3);
    rd(8'h54, d); check("R11 latch kept", d, 16'h0);
    eng_sda_low = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_engine_follow();
    t_gpio_drive();
    t_set_clear();
    t_unmapped();
    t_sync();
    t_handback();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule